// File: doc/BRIEF.md
# ATA Data Strobe Timing Generator

This block generates the active-low read and write data strobes for a parallel ATA drive port, counting all intervals in cycles of a single 30 MHz clock (about 33 ns per cycle). A transfer request carries a direction and a flag that marks it as a non-Ultra DMA transfer or a PIO transfer. Three fields of a timing register set the timing. The first field sets the clocks from strobe assertion to the first IORDY sample. The second sets the recovery clocks. A single bit selects which transfer types use fast timing.

In compatible timing the strobe is held asserted while the drive pulls IORDY low. A watchdog count ends an IORDY stall. In fast timing the two counts set fixed active and inactive strobe widths, and IORDY is not used. The block captures read data when the read strobe is released. It drives write data from one clock before the write strobe falls until recovery begins. It reports `busy` during the whole transfer and gives a one-clock `done` at the end of recovery.

Top module: `ata_strobe_timer`

## Requirements
- R1: After reset both strobes are high, and `busy`, `done`, `timeout_err` and `wr_bus_oe` are low.
- R2: Bits 7:6 of `tim_cfg` set the active count: 00 gives 5 clocks, 01 gives 4, 10 gives 3 and 11 gives 2. In compatible timing with IORDY high at the sample point, the strobe stays low for exactly that many clocks.
- R3: In compatible timing, IORDY is sampled at the end of the last active clock and at the end of every later clock. The strobe is released after the first clock that samples IORDY high, so d extra low clocks of IORDY lengthen the strobe by d clocks.
- R4: In fast timing the strobe stays low for exactly the active count, whatever IORDY does.
- R5: Bits 5:4 set the recovery count: 00 gives 4 clocks, 01 gives 3, 10 gives 2 and 11 gives 1. After the strobe is released, `busy` stays high with both strobes high for exactly that many clocks. `done` follows in the next clock.
- R6: With bit 3 set, only DMA requests (`req_dma`=1) use fast timing and PIO requests use compatible timing. With bit 3 clear, every request uses fast timing.
- R7: A write (`req_write`=1) pulses only `wr_strobe_n` and a read pulses only `rd_strobe_n`. The two strobes are never low together.
- R8: `rd_data` takes the value that `rd_bus_in` holds in the last clock of the read strobe low time, and holds it until the next read strobe release.
- R9: For a write, `wr_bus_oe` is high from one clock before `wr_strobe_n` falls through the last low clock, and low from the release onward. `wr_bus_out` carries the `wr_data` given with the request.
- R10: A request made while `busy` is high is ignored. No further strobe follows the current transfer.
- R11: `done` is high for exactly one clock with `busy` low. A request made in that same clock is accepted.
- R12: In compatible timing, if IORDY is still low `TIMEOUT_CLKS` clocks after the first sample, the strobe is released anyway. `timeout_err` is then high together with `done`. If IORDY goes high on the last of those clocks, the transfer ends normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 30 MHz timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tim_cfg | input | 5 | Timing register bits 7:3 (active count, recovery count, DMA-only fast bit) |
| req_valid | input | 1 | Transfer request, taken when `busy` is low |
| req_write | input | 1 | 1 = write to drive, 0 = read from drive |
| req_dma | input | 1 | 1 = non-Ultra DMA transfer, 0 = PIO transfer |
| wr_data | input | DATA_W | Write data given with the request |
| rd_bus_in | input | DATA_W | Data bus from the drive |
| iordy | input | 1 | Drive ready |
| rd_strobe_n | output | 1 | Read strobe, active low |
| wr_strobe_n | output | 1 | Write strobe, active low |
| wr_bus_out | output | DATA_W | Write data toward the drive |
| wr_bus_oe | output | 1 | Drive enable for `wr_bus_out` |
| rd_data | output | DATA_W | Captured read data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock end-of-transfer pulse |
| timeout_err | output | 1 | IORDY stall timeout, valid with `done` |

## Verification
The bench builds the block with `DATA_W`=8 and `TIMEOUT_CLKS`=16. The short timeout lets the bench reach both sides of the IORDY watchdog, and the exact boundary where IORDY rises on the last allowed clock, within a few dozen clocks. The bench sweeps every combination of active code, recovery code, mode bit, direction and transfer type, each with IORDY ready at the sample point and with IORDY held low for two extra clocks. It derives the expected widths from the code arithmetic (5 minus the code, 4 minus the code).

// File: rtl/ata_strobe_pkg.sv
package ata_strobe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_ACTIVE  = 3'd2,
    ST_WAIT    = 3'd3,
    ST_RECOVER = 3'd4
  } xfer_state_t;

  typedef struct packed {
    logic [2:0] act_clks;
    logic [2:0] rec_clks;
    logic       fast;
  } xfer_timing_t;

  localparam logic [2:0] ACT_BASE = 3'd5;
  localparam logic [2:0] REC_BASE = 3'd4;

endpackage

// File: rtl/ata_rst_sync.sv
module ata_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/ata_tim_decode.sv
module ata_tim_decode
  import ata_strobe_pkg::*;
(
  input  logic [7:3]   cfg,
  input  logic         is_dma,
  output xfer_timing_t timing
);

  // Codes count down from the base: larger code, shorter interval.
  always_comb begin
    timing.act_clks = ACT_BASE - {1'b0, cfg[7:6]};
    timing.rec_clks = REC_BASE - {1'b0, cfg[5:4]};
    // Bit 3 set restricts fast timing to DMA; clear gives fast timing to all.
    timing.fast     = ~cfg[3] | is_dma;
  end

endmodule

// File: rtl/ata_xfer_fsm.sv
module ata_xfer_fsm
  import ata_strobe_pkg::*;
#(
  parameter int unsigned TIMEOUT_CLKS = 1024
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         start_write,
  input  xfer_timing_t timing_in,
  input  logic         iordy,
  output logic         busy,
  output logic         strobe_on,
  output logic         dir_write,
  output logic         data_oe,
  output logic         capture,
  output logic         done,
  output logic         timed_out
);

  localparam int unsigned CNT_W = (TIMEOUT_CLKS > 8) ? $clog2(TIMEOUT_CLKS) : 3;
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TIMEOUT_CLKS - 1);

  xfer_state_t      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [2:0]       rec_q;
  logic             fast_q;
  logic             dir_q, dir_d;
  logic             tmo_q, tmo_d;
  logic             done_q, done_d;
  logic             strobe_q, strobe_d;
  logic             oe_q, oe_d;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    tmo_d   = tmo_q;
    done_d  = 1'b0;
    capture = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_SETUP;
          cnt_d   = CNT_W'(timing_in.act_clks - 3'd1);
          tmo_d   = 1'b0;
        end
      end
      ST_SETUP: begin
        state_d = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (cnt_q == '0) begin
          if (fast_q || iordy) begin
            state_d = ST_RECOVER;
            cnt_d   = CNT_W'(rec_q - 3'd1);
            capture = 1'b1;
          end else begin
            state_d = ST_WAIT;
            cnt_d   = '0;
          end
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      ST_WAIT: begin
        if (iordy) begin
          state_d = ST_RECOVER;
          cnt_d   = CNT_W'(rec_q - 3'd1);
          capture = 1'b1;
        end else if (cnt_q == TMO_LAST) begin
          state_d = ST_RECOVER;
          cnt_d   = CNT_W'(rec_q - 3'd1);
          capture = 1'b1;
          tmo_d   = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_RECOVER: begin
        if (cnt_q == '0) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase

    dir_d    = start ? start_write : dir_q;
    strobe_d = (state_d == ST_ACTIVE) || (state_d == ST_WAIT);
    oe_d     = dir_d && ((state_d == ST_SETUP) || strobe_d);
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      tmo_q    <= 1'b0;
      done_q   <= 1'b0;
      strobe_q <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      tmo_q    <= tmo_d;
      done_q   <= done_d;
      strobe_q <= strobe_d;
      oe_q     <= oe_d;
    end
  end

  // Per-transfer attributes, loaded only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= 1'b0;
      fast_q <= 1'b0;
      rec_q  <= 3'd1;
    end else if (start) begin
      dir_q  <= start_write;
      fast_q <= timing_in.fast;
      rec_q  <= timing_in.rec_clks;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign strobe_on = strobe_q;
  assign dir_write = dir_q;
  assign data_oe   = oe_q;
  assign done      = done_q;
  assign timed_out = tmo_q;

endmodule

// File: rtl/ata_data_path.sv
module ata_data_path #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_wr,
  input  logic [DATA_W-1:0] wr_in,
  input  logic              capture_en,
  input  logic              capture_rd,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] wr_out,
  output logic [DATA_W-1:0] rd_out
);

  logic [DATA_W-1:0] wr_q;
  logic [DATA_W-1:0] rd_q;
  logic              rd_en;

  assign rd_en = capture_en & capture_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
    end else if (load_wr) begin
      wr_q <= wr_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= bus_in;
    end
  end

  assign wr_out = wr_q;
  assign rd_out = rd_q;

endmodule

// File: rtl/ata_strobe_timer.sv
module ata_strobe_timer
  import ata_strobe_pkg::*;
#(
  parameter int unsigned DATA_W       = 16,
  parameter int unsigned TIMEOUT_CLKS = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:3]        tim_cfg,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_dma,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] rd_bus_in,
  input  logic              iordy,
  output logic              rd_strobe_n,
  output logic              wr_strobe_n,
  output logic [DATA_W-1:0] wr_bus_out,
  output logic              wr_bus_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              timeout_err
);

  logic         rst_n_int;
  xfer_timing_t timing;
  logic         start;
  logic         strobe_on;
  logic         dir_write;
  logic         capture;
  logic         timed_out;

  ata_rst_sync u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  ata_tim_decode u_decode (
    .cfg    (tim_cfg),
    .is_dma (req_dma),
    .timing (timing)
  );

  assign start = req_valid & ~busy;

  ata_xfer_fsm #(
    .TIMEOUT_CLKS (TIMEOUT_CLKS)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .start       (start),
    .start_write (req_write),
    .timing_in   (timing),
    .iordy       (iordy),
    .busy        (busy),
    .strobe_on   (strobe_on),
    .dir_write   (dir_write),
    .data_oe     (wr_bus_oe),
    .capture     (capture),
    .done        (done),
    .timed_out   (timed_out)
  );

  ata_data_path #(
    .DATA_W (DATA_W)
  ) u_data (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .load_wr    (start),
    .wr_in      (wr_data),
    .capture_en (capture),
    .capture_rd (~dir_write),
    .bus_in     (rd_bus_in),
    .wr_out     (wr_bus_out),
    .rd_out     (rd_data)
  );

  assign rd_strobe_n = ~(strobe_on & ~dir_write);
  assign wr_strobe_n = ~(strobe_on & dir_write);
  assign timeout_err = done & timed_out;

endmodule

// File: rtl/ata_strobe_timer_chk.sv
module ata_strobe_timer_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_strobe_n,
  input logic              wr_strobe_n,
  input logic              wr_bus_oe,
  input logic [DATA_W-1:0] rd_data,
  input logic              busy,
  input logic              done,
  input logic              timeout_err
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe_n || wr_strobe_n);  // R7

  AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_strobe_n || !wr_strobe_n) |-> busy);  // R10

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R11

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);  // R11

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> done);  // R12

  AST_OE_LEADS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_strobe_n) |-> $past(wr_bus_oe));  // R9

  AST_OE_OFF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_strobe_n) |-> !wr_bus_oe);  // R9

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(rd_strobe_n) |-> $stable(rd_data));  // R8

endmodule

bind ata_strobe_timer ata_strobe_timer_chk #(
  .DATA_W (DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_strobe_n (rd_strobe_n),
  .wr_strobe_n (wr_strobe_n),
  .wr_bus_oe   (wr_bus_oe),
  .rd_data     (rd_data),
  .busy        (busy),
  .done        (done),
  .timeout_err (timeout_err)
);

// File: tb/ata_strobe_timer_bench.sv
`timescale 1ns/1ps
module ata_strobe_timer_bench;

  localparam int DW  = 8;
  localparam int TMO = 16;

  logic          clk;
  logic          rst_n;
  logic [7:3]    tim_cfg;
  logic          req_valid, req_write, req_dma;
  logic [DW-1:0] wr_data, rd_bus_in;
  logic          iordy;
  logic          rd_strobe_n, wr_strobe_n, wr_bus_oe, busy, done, timeout_err;
  logic [DW-1:0] wr_bus_out, rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  int seed     = 0;

  ata_strobe_timer #(.DATA_W(DW), .TIMEOUT_CLKS(TMO)) u_ata_strobe_timer (
    .clk(clk), .rst_n(rst_n), .tim_cfg(tim_cfg), .req_valid(req_valid),
    .req_write(req_write), .req_dma(req_dma), .wr_data(wr_data),
    .rd_bus_in(rd_bus_in), .iordy(iordy), .rd_strobe_n(rd_strobe_n),
    .wr_strobe_n(wr_strobe_n), .wr_bus_out(wr_bus_out), .wr_bus_oe(wr_bus_oe),
    .rd_data(rd_data), .busy(busy), .done(done), .timeout_err(timeout_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One transfer, sampled at falling edges. d = extra IORDY-low clocks past the sample point.
  task automatic xfer(input logic [7:3] cfg, input bit wr, input bit dma, input int d,
                      input bit poke, input bit chain);
    int  sp, rec, expw, low, after, oecnt, badother, baddata, target;
    bit  fast, experr, got_done, errseen;
    logic [DW-1:0] dat, last_rd;
    sp     = 5 - int'(cfg[7:6]);
    rec    = 4 - int'(cfg[5:4]);
    fast   = !cfg[3] || dma;
    experr = !fast && (d > TMO);
    expw   = fast ? sp : sp + ((d > TMO) ? TMO : d);
    target = fast ? 100000 : sp + d;
    dat    = DW'(seed * 37 + 11);
    seed++;
    low = 0; after = 0; oecnt = 0; badother = 0; baddata = 0;
    got_done = 0; errseen = 0; last_rd = '0;

    @(negedge clk);
    tim_cfg   = cfg;
    req_valid = 1'b1;
    req_write = wr;
    req_dma   = dma;
    wr_data   = dat;
    iordy     = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    wr_data   = ~dat;
    for (int i = 0; i < 200; i++) begin
      logic s, o;
      s = wr ? wr_strobe_n : rd_strobe_n;
      o = wr ? rd_strobe_n : wr_strobe_n;
      if (!o) badother++;
      if (wr_bus_oe) begin
        oecnt++;
        if (wr_bus_out !== dat) baddata++;
      end
      req_valid = 1'b0;
      if (done) begin
        got_done = 1;
        errseen  = timeout_err;
        break;
      end
      if (!s) begin
        low++;
        if (poke && low == 1) begin
          req_valid = 1'b1;
          req_write = !wr;
        end
        rd_bus_in = DW'(seed * 13 + i * 5 + 3);
        last_rd   = rd_bus_in;
      end else if (low > 0) begin
        if (after == 0 && !wr)
          check(rd_data === last_rd, "R8 read capture", int'(rd_data), int'(last_rd));
        if (busy) after++;
      end
      iordy = (!s && low >= target);
      @(negedge clk);
    end
    iordy = 1'b0;
    check(got_done, "R11 done reached", int'(got_done), 1);
    if (fast)
      check(low == expw, "R4 fast width", low, expw);
    else if (d == 0)
      check(low == expw, "R2 sample-point width", low, expw);
    else if (d <= TMO)
      check(low == expw, "R3 IORDY extended width", low, expw);
    else
      check(low == expw, "R12 timeout width", low, expw);
    check(after == rec, "R5 recovery clocks", after, rec);
    check(errseen == experr, "R12 timeout flag", int'(errseen), int'(experr));
    check(badother == 0, "R7 opposite strobe quiet", badother, 0);
    check(oecnt == (wr ? expw + 1 : 0), "R9 write enable span", oecnt, wr ? expw + 1 : 0);
    if (wr) check(baddata == 0, "R9 write data", baddata, 0);
    if (chain) begin
      req_valid = 1'b1;
      req_write = 1'b0;
      req_dma   = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(busy === 1'b1, "R11 accept in done clock", int'(busy), 1);
      for (int i = 0; i < 200 && !done; i++) begin
        iordy = 1'b1;
        @(negedge clk);
      end
      iordy = 1'b0;
      check(done === 1'b1, "R11 chained done", int'(done), 1);
    end
    @(negedge clk);
    check(done === 1'b0, "R11 done one clock", int'(done), 0);
    check(busy === 1'b0, "R11 idle after done", int'(busy), 0);
    if (poke) begin
      int strobes;
      strobes = 0;
      for (int i = 0; i < 12; i++) begin
        if (!rd_strobe_n || !wr_strobe_n || busy) strobes++;
        @(negedge clk);
      end
      check(strobes == 0, "R10 busy request ignored", strobes, 0);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    tim_cfg = '0; req_valid = 0; req_write = 0; req_dma = 0;
    wr_data = '0; rd_bus_in = '0; iordy = 0;
    repeat (3) @(negedge clk);
    check(rd_strobe_n === 1'b1 && wr_strobe_n === 1'b1, "R1 strobes idle high",
          int'({rd_strobe_n, wr_strobe_n}), 3);
    check(busy === 0 && done === 0 && timeout_err === 0 && wr_bus_oe === 0,
          "R1 status low", int'({busy, done, timeout_err, wr_bus_oe}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(rd_strobe_n === 1'b1 && wr_strobe_n === 1'b1 && busy === 0,
          "R1 idle after release", int'({rd_strobe_n, wr_strobe_n, busy}), 6);

    // R2..R9 and R6 sweep: all codes, mode bit, direction, transfer type
    for (int a = 0; a < 4; a++)
      for (int r = 0; r < 4; r++)
        for (int m = 0; m < 2; m++)
          for (int w = 0; w < 2; w++)
            for (int k = 0; k < 2; k++)
              for (int dd = 0; dd < 2; dd++)
                xfer({a[1:0], r[1:0], m[0]}, w[0], k[0], dd * 2, 1'b0, 1'b0);

    // R12 boundary: IORDY rises on last allowed clock, and never rises
    xfer(5'b00_00_1, 1'b0, 1'b0, TMO, 1'b0, 1'b0);
    xfer(5'b11_11_1, 1'b1, 1'b0, TMO + 5, 1'b0, 1'b0);
    xfer(5'b01_10_1, 1'b0, 1'b0, TMO + 1, 1'b0, 1'b0);
    // R6: fast PIO under cleared bit ignores a long stall
    xfer(5'b00_00_0, 1'b0, 1'b0, TMO + 5, 1'b0, 1'b0);
    // R10: request during strobe ignored
    xfer(5'b00_00_1, 1'b1, 1'b0, 1, 1'b1, 1'b0);
    xfer(5'b10_01_0, 1'b0, 1'b1, 0, 1'b1, 1'b0);
    // R11: request in the done clock is accepted
    xfer(5'b11_11_0, 1'b1, 1'b1, 0, 1'b0, 1'b1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule